// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator with IRQ/FIQ Steering

This block gathers 64 interrupt request inputs into two banks of 32 and drives two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Each input can be set to level or edge sensing. It also has its own active sense, its own destination line and its own enable. A software-raised request can stand in for any input.

Software reaches the block through a simple word-wide register port with separate read and write strobes. Through this port it configures the sources, changes enables with write-one-to-set and write-one-to-clear registers, and acknowledges latched edges. It can also read three views of pending state and fetch the number of the lowest pending normal request. Both request lines are registered, and each one is gated by its own bit of a two-bit master enable. The inputs must already be synchronous to `clk`.

Top module: `vic_dual_bank`

## Requirements
- R1: Source n is controlled by bit n[4:0] of a bank register pair. Addr[2]=0 selects sources 0–31 and addr[2]=1 selects sources 32–63, so the upper bank sits 4 bytes above the lower one.
- R2: Destination registers are at 0x00/0x04. A 1 steers the source to `fiq_o` and a 0 steers it to `irq_o`.
- R3: Trigger registers are at 0x40/0x44. With a 0 the source is level-sensed, and its pending state follows the conditioned input every cycle.
- R4: Sense registers are at 0x50/0x54. A 1 makes low level or falling edge active, and a 0 makes high level or rising edge active.
- R5: Writing 0x10/0x14 loads the enables directly. Ones written to 0x30/0x34 set enables, and ones written to 0x20/0x24 clear them. Zero bits written to 0x20/0x24/0x30/0x34 leave the enables unchanged.
- R6: With a 1 in the trigger register, an inactive-to-active transition of the conditioned input sets a pending latch. The latch holds until a 1 is written to the source's bit at 0xB0/0xB4. If a new edge and the acknowledge arrive in the same cycle, the new edge wins.
- R7: Register 0x64 holds the master enable: bit 0 gates `irq_o` and bit 1 gates `fiq_o`. Each line is registered, and it is high the cycle after its master bit is set while at least one enabled source steered to it is pending.
- R8: Status reads give pending state per bank. 0xA0/0xA4 give raw pending state, 0x80/0x84 give pending AND enabled AND steered to IRQ, and 0x90/0x94 give pending AND enabled AND steered to FIQ. Read data is registered and is valid the cycle after `rd_en`.
- R9: Software request registers are at 0xC0/0xC4. A 1 makes the source active regardless of its input pin or sense bit.
- R10: Reading 0xD0 returns the number of the lowest-numbered source that is pending, enabled and steered to IRQ. If there is none, it returns the value of the read/write register at 0x60, which resets to 64.
- R11: After reset, all destination, trigger, sense, enable, software request and master bits read 0, and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src_in | input | 64 | Interrupt request inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Directed patterns come first, and each one isolates a single control:
- a held-high level input, which separates level following from latching;
- a low input with the sense bit set, which exposes polarity;
- a one-cycle pulse on an edge source, which shows that the latch survives the input's return and clears only on acknowledge;
- sources in both banks pending together, which exposes the lowest-number choice and the bank offset.

A random phase then mixes pin changes, configuration writes, acknowledges and software requests. After every step it compares all status views, the pending number and both lines against a bench model. That comparison separates routing errors from masking errors and from edge-latch bookkeeping errors.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef logic [7:0] vaddr_t;
  // word-aligned bank bases; addr[2] picks the upper bank
  localparam vaddr_t A_ROUTE  = 8'h00;
  localparam vaddr_t A_EN     = 8'h10;
  localparam vaddr_t A_ENCLR  = 8'h20;
  localparam vaddr_t A_ENSET  = 8'h30;
  localparam vaddr_t A_TRIG   = 8'h40;
  localparam vaddr_t A_SENSE  = 8'h50;
  localparam vaddr_t A_NOPEND = 8'h60;
  localparam vaddr_t A_MASTER = 8'h64;
  localparam vaddr_t A_IRQST  = 8'h80;
  localparam vaddr_t A_FIQST  = 8'h90;
  localparam vaddr_t A_RAW    = 8'hA0;
  localparam vaddr_t A_ACK    = 8'hB0;
  localparam vaddr_t A_SOFT   = 8'hC0;
  localparam vaddr_t A_PNUM   = 8'hD0;
endpackage

// File: rtl/vic_cond.sv
// Per-source conditioning: polarity, software request, edge latch.
module vic_cond #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] soft_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic act, act_q, lat;
    assign act = (src_i[g] ^ sense_i[g]) | soft_i[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        act_q <= 1'b0;
        lat   <= 1'b0;
      end else begin
        act_q <= act;
        // a fresh edge outranks an acknowledge in the same cycle
        lat   <= trig_i[g] & ((lat & ~ack_i[g]) | (act & ~act_q));
      end
    end
    assign pend_o[g] = trig_i[g] ? lat : act;
  end
endmodule

// File: rtl/vic_lowest.sv
// Lowest set index finder.
module vic_lowest #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/vic_dual_bank.sv
module vic_dual_bank
  import vic_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NOPEND_INIT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [2*DATA_W-1:0] src_in,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int NUM_SRC = 2 * DATA_W;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [DATA_W-1:0] route_b [2];
  logic [DATA_W-1:0] en_b    [2];
  logic [DATA_W-1:0] trig_b  [2];
  logic [DATA_W-1:0] sense_b [2];
  logic [DATA_W-1:0] soft_b  [2];
  logic [1:0]        master_q;
  logic [DATA_W-1:0] nopend_q;

  logic [NUM_SRC-1:0] route_v, en_v, trig_v, sense_v, soft_v;
  logic [NUM_SRC-1:0] ack_v, pend_v, irq_st, fiq_st;
  logic [7:0]         base;
  logic               hi;
  logic               pn_hit;
  logic [IDX_W-1:0]   pn_idx;
  logic [DATA_W-1:0]  rd_mux;

  assign base = {addr[7:3], 3'b000};
  assign hi   = addr[2];

  assign route_v = {route_b[1], route_b[0]};
  assign en_v    = {en_b[1],    en_b[0]};
  assign trig_v  = {trig_b[1],  trig_b[0]};
  assign sense_v = {sense_b[1], sense_b[0]};
  assign soft_v  = {soft_b[1],  soft_b[0]};

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        route_b[b] <= '0;
        en_b[b]    <= '0;
        trig_b[b]  <= '0;
        sense_b[b] <= '0;
        soft_b[b]  <= '0;
      end
      master_q <= '0;
      nopend_q <= DATA_W'(NOPEND_INIT);
    end else if (wr_en) begin
      case (base)
        A_ROUTE:  route_b[hi] <= wdata;
        A_EN:     en_b[hi]    <= wdata;
        A_ENCLR:  en_b[hi]    <= en_b[hi] & ~wdata;
        A_ENSET:  en_b[hi]    <= en_b[hi] | wdata;
        A_TRIG:   trig_b[hi]  <= wdata;
        A_SENSE:  sense_b[hi] <= wdata;
        A_SOFT:   soft_b[hi]  <= wdata;
        A_NOPEND: begin
          if (hi) master_q <= wdata[1:0];
          else    nopend_q <= wdata;
        end
        default: ;
      endcase
    end
  end

  // acknowledge pulse aligned to the addressed bank
  always_comb begin
    ack_v = '0;
    if (wr_en && base == A_ACK)
      ack_v = hi ? {wdata, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, wdata};
  end

  vic_cond #(.N(NUM_SRC)) u_cond (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src_in),
    .sense_i (sense_v),
    .soft_i  (soft_v),
    .trig_i  (trig_v),
    .ack_i   (ack_v),
    .pend_o  (pend_v)
  );

  assign irq_st = pend_v & en_v & ~route_v;
  assign fiq_st = pend_v & en_v & route_v;

  vic_lowest #(.N(NUM_SRC), .W(IDX_W)) u_low (
    .vec_i (irq_st),
    .hit_o (pn_hit),
    .idx_o (pn_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= master_q[0] & (|irq_st);
      fiq_o <= master_q[1] & (|fiq_st);
    end
  end

  // read mux
  always_comb begin
    case (base)
      A_ROUTE:  rd_mux = route_b[hi];
      A_EN:     rd_mux = en_b[hi];
      A_TRIG:   rd_mux = trig_b[hi];
      A_SENSE:  rd_mux = sense_b[hi];
      A_SOFT:   rd_mux = soft_b[hi];
      A_NOPEND: rd_mux = hi ? DATA_W'(master_q) : nopend_q;
      A_IRQST:  rd_mux = hi ? irq_st[NUM_SRC-1:DATA_W] : irq_st[DATA_W-1:0];
      A_FIQST:  rd_mux = hi ? fiq_st[NUM_SRC-1:DATA_W] : fiq_st[DATA_W-1:0];
      A_RAW:    rd_mux = hi ? pend_v[NUM_SRC-1:DATA_W] : pend_v[DATA_W-1:0];
      A_PNUM:   rd_mux = hi ? '0 : (pn_hit ? DATA_W'(pn_idx) : nopend_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/vic_dual_bank_chk.sv
module vic_dual_bank_chk
  import vic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [7:0]          addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [2*DATA_W-1:0] en_v,
  input logic [2*DATA_W-1:0] trig_v,
  input logic [2*DATA_W-1:0] pend_v,
  input logic [1:0]          master_q,
  input logic [DATA_W-1:0]   nopend_q
);
  localparam int NUM_SRC = 2 * DATA_W;

  AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENSET) |=> ((en_v[DATA_W-1:0] & $past(wdata)) == $past(wdata))); // R5
  AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENCLR) |=> ((en_v[DATA_W-1:0] & $past(wdata)) == '0)); // R5
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr[7:3] == A_ACK[7:3]) |=>
      ((pend_v & trig_v & $past(pend_v & trig_v)) == (trig_v & $past(pend_v & trig_v)))); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(master_q[0])); // R7
  AST_FIQ_GATED: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(master_q[1])); // R7
  AST_PNUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_PNUM) |=> (rdata < DATA_W'(NUM_SRC) || rdata == $past(nopend_q))); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o)); // R11
endmodule

bind vic_dual_bank vic_dual_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .en_v     (en_v),
  .trig_v   (trig_v),
  .pend_v   (pend_v),
  .master_q (master_q),
  .nopend_q (nopend_q)
);

// File: tb/sim_vic_dual_bank.sv
`timescale 1ns/1ps
module sim_vic_dual_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_in = '0;
  logic        irq_o, fiq_o;

  int total = 0, bad = 0;

  // bench model state
  logic [63:0] m_route = '0, m_trig = '0, m_sense = '0, m_en = '0;
  logic [63:0] m_sw = '0, m_lat = '0, m_src = '0, m_prev = '0;
  logic [1:0]  m_master = '0;
  logic [31:0] m_nopend = 32'd64;

  always #2.5 clk = ~clk;

  vic_dual_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] m_act();
    return (m_src ^ m_sense) | m_sw;
  endfunction

  function automatic logic [63:0] m_pend();
    return (m_trig & m_lat) | (~m_trig & m_act());
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int lo;
    lo = a[2] ? 32 : 0;
    case ({a[7:3], 3'b000})
      8'h00: m_route[lo +: 32] = d;
      8'h10: m_en[lo +: 32] = d;
      8'h20: m_en[lo +: 32] = m_en[lo +: 32] & ~d;
      8'h30: m_en[lo +: 32] = m_en[lo +: 32] | d;
      8'h40: m_trig[lo +: 32] = d;
      8'h50: m_sense[lo +: 32] = d;
      8'h60: if (a[2]) m_master = d[1:0]; else m_nopend = d;
      8'hB0: m_lat[lo +: 32] = m_lat[lo +: 32] & ~d;
      8'hC0: m_sw[lo +: 32] = d;
      default: ;
    endcase
    m_lat = m_lat & m_trig;
  endtask

  task automatic settle();
    logic [63:0] a;
    repeat (3) @(negedge clk);
    a = m_act();
    m_lat = m_lat | (m_trig & a & ~m_prev);
    m_prev = a;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    settle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic drive_src(input logic [63:0] v);
    @(negedge clk);
    src_in = v; m_src = v;
    settle();
  endtask

  task automatic check_all(input string tag);
    logic [63:0] p, is, fs;
    logic [31:0] v, pn;
    p  = m_pend();
    is = p & m_en & ~m_route;
    fs = p & m_en & m_route;
    pn = m_nopend;
    for (int i = 63; i >= 0; i--) if (is[i]) pn = i;
    rd(8'hA0, v); chk({tag, " raw0"}, v, p[31:0]);
    rd(8'hA4, v); chk({tag, " raw1"}, v, p[63:32]);
    rd(8'h80, v); chk({tag, " irqst0"}, v, is[31:0]);
    rd(8'h84, v); chk({tag, " irqst1"}, v, is[63:32]);
    rd(8'h90, v); chk({tag, " fiqst0"}, v, fs[31:0]);
    rd(8'h94, v); chk({tag, " fiqst1"}, v, fs[63:32]);
    rd(8'hD0, v); chk({tag, " pnum"}, v, pn);
    chk({tag, " irq_o"}, {31'd0, irq_o}, {31'd0, m_master[0] & (|is)});
    chk({tag, " fiq_o"}, {31'd0, fiq_o}, {31'd0, m_master[1] & (|fs)});
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq_o", {31'd0, irq_o}, 32'd0);
    chk("R11 fiq_o", {31'd0, fiq_o}, 32'd0);
    rd(8'h10, v); chk("R11 en0", v, 32'd0);
    rd(8'h44, v); chk("R11 trig1", v, 32'd0);
    rd(8'h64, v); chk("R11 master", v, 32'd0);
    rd(8'hD0, v); chk("R10 reset nopend", v, 32'd64);

    // R1 bank offset
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, v); chk("R1 route1", v, 32'h0000_0100);
    rd(8'h00, v); chk("R1 route0", v, 32'd0);
    wr(8'h04, 32'd0);

    // R3 level source follows input
    wr(8'h64, 32'd1);
    wr(8'h30, 32'h0000_0008);
    drive_src(64'h8);
    check_all("R3 level high");
    chk("R3 irq up", {31'd0, irq_o}, 32'd1);
    drive_src(64'h0);
    check_all("R3 level low");

    // R4 active-low sense
    wr(8'h50, 32'h0000_0008);
    check_all("R4 low active");
    chk("R4 irq up", {31'd0, irq_o}, 32'd1);
    wr(8'h50, 32'd0);

    // R6 edge latch on source 40, acknowledge
    wr(8'h44, 32'h0000_0100);
    wr(8'h34, 32'h0000_0100);
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk); src_in[40] = 1'b0;
    m_lat[40] = 1'b1;
    settle();
    check_all("R6 latched");
    rd(8'hD0, v); chk("R6 pnum40", v, 32'd40);
    wr(8'hB4, 32'h0000_0100);
    check_all("R6 acked");

    // R5 set/clear with zero bits
    wr(8'h10, 32'hA5A5_0F0F);
    wr(8'h30, 32'd0);
    wr(8'h20, 32'd0);
    rd(8'h10, v); chk("R5 zero bits", v, 32'hA5A5_0F0F);
    wr(8'h20, 32'h0000_000F);
    rd(8'h10, v); chk("R5 clear", v, 32'hA5A5_0F00);
    wr(8'h30, 32'h0000_0030);
    rd(8'h10, v); chk("R5 set", v, 32'hA5A5_0F30);

    // R2 route to FIQ, R7 master gating
    wr(8'h10, 32'd0);
    wr(8'h14, 32'h0000_0001);
    wr(8'h04, 32'h0000_0001);
    drive_src(64'h1_0000_0000);
    check_all("R7 fiq masked");
    chk("R7 fiq low", {31'd0, fiq_o}, 32'd0);
    wr(8'h64, 32'd2);
    check_all("R2 fiq route");
    chk("R2 fiq high", {31'd0, fiq_o}, 32'd1);

    // R9 software request, R10 lowest number and nopend register
    wr(8'h64, 32'd3);
    wr(8'h04, 32'd0);
    wr(8'h10, 32'h0000_0220);
    wr(8'hC0, 32'h0000_0220);
    check_all("R9 soft");
    rd(8'hD0, v); chk("R10 lowest", v, 32'd5);
    wr(8'hC0, 32'd0);
    wr(8'h14, 32'd0);
    wr(8'h60, 32'h0000_00FF);
    rd(8'hD0, v); chk("R10 nopend reg", v, 32'h0000_00FF);

    // R8 random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      logic [7:0] hb;
      op = $urandom_range(0, 9);
      hb = ($urandom_range(0, 1) != 0) ? 8'h04 : 8'h00;
      case (op)
        0, 1, 2: drive_src({$urandom, $urandom});
        3: wr(8'h00 | hb, $urandom);
        4: wr(8'h40 | hb, $urandom);
        5: wr(8'h50 | hb, $urandom);
        6: wr(8'h10 + 8'h10 * 8'($urandom_range(0, 2)) | hb, $urandom);
        7: wr(8'hB0 | hb, $urandom);
        8: wr(8'hC0 | hb, $urandom & $urandom & $urandom);
        default: wr(8'h64, $urandom);
      endcase
      check_all("R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule